// File: doc/BRIEF.md
# Indexed Frame Buffer Pixel Expander

This block scans an 8-bit-per-pixel frame buffer and turns every stored byte, a palette index, into a pixel word for a display sink. On a frame start it samples an output format, an active width and an active height. It then walks the visible lines from top to bottom and the pixels of each line from left to right. Each index comes through a one-cycle-latency byte read port. It is then translated through a one-cycle-latency palette port, or passed through untouched in raw mode. The result is presented on a valid/ready stream with a byte-enable mask and line and frame markers.

Source lines sit a fixed pitch apart (1024 bytes by default), whatever the active width. Lines are processed in bands of four. At the start of every band the block asks an external update map whether that band needs refreshing. A band that does not is skipped as a whole, but its address space is still stepped over.

The controller is a single state machine with these states: `S_IDLE` (waiting for a frame start), `S_GROUP` (band decision), `S_FETCH` (byte read issued), `S_IDXCAP` (index captured), `S_LOOKUP` (palette read issued), `S_RGBCAP` (colour captured) and `S_EMIT` (pixel offered to the sink). Its transitions are:
- `S_IDLE` to `S_GROUP` on an accepted frame start.
- `S_GROUP` to `S_FETCH` when the band is enabled.
- `S_GROUP` back to `S_GROUP` on a skip, or to `S_IDLE` when the skip reaches the height.
- `S_FETCH` to `S_IDXCAP`.
- `S_IDXCAP` to `S_EMIT` in raw mode, otherwise to `S_LOOKUP`.
- `S_LOOKUP` to `S_RGBCAP`, and `S_RGBCAP` to `S_EMIT`.
- `S_EMIT`, once the sink accepts the pixel, to `S_FETCH` for the next pixel, to `S_GROUP` after the fourth line of a band, or to `S_IDLE` after the final pixel of the frame.

Top module: `idx_scanout`

## Requirements
- R1: After reset, and until a frame is accepted, `pix_valid`, `mem_rd` and `pal_rd` are low.
- R2: A `frame_start` pulse seen while idle with a nonzero mode, width and height starts a frame. Mode, width and height are sampled in that cycle, so later changes to those inputs, and further `frame_start` pulses during the frame, do not alter it.
- R3: The byte for line y and column x is read at address y*1024 + x, with x running from 0 to width-1. At most one read is issued per cycle, never in two consecutive cycles, and the data is taken on `mem_rdata` in the cycle after `mem_rd`.
- R4: Mode 2'b11 (padded 32-bit) emits byte 0 = blue, byte 1 = green, byte 2 = red and byte 3 = 0, with `pix_be` = 4'b1111.
- R5: Mode 2'b10 (packed 24-bit) emits byte 0 = blue, byte 1 = green, byte 2 = red and byte 3 = 0, with `pix_be` = 4'b0111.
- R6: Mode 2'b01 (raw) emits the index in byte 0 and zero in the other bytes, with `pix_be` = 4'b0001, and never asserts `pal_rd`.
- R7: Mode 2'b00 ignores `frame_start`: no read is issued and no pixel is emitted.
- R8: At the first line of each band of four, `grp_sel` = line/4 and `grp_en` is sampled. When it is low, up to four lines are skipped without reads, and the next band still starts four pitches further on.
- R9: `pix_sol` is high on every column-0 pixel. `pix_eof` is high only on the last pixel of the last line, so a frame whose final band is skipped carries no `pix_eof`.
- R10: While `pix_valid` is high and `pix_ready` is low, data, enables and markers stay stable. No pixel is lost or repeated under any ready pattern.
- R11: A width of 1024 (the maximum) reads columns 0 to 1023 of a line and emits 1024 pixels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Frame start request pulse |
| mode | input | 2 | Output format: 00 off, 01 raw, 10 packed 24-bit, 11 padded 32-bit |
| act_width | input | 11 | Active pixels per line, 1 to 1024 |
| act_height | input | 10 | Active lines, 1 to 768 |
| grp_sel | output | 8 | Index of the band of four lines being decided |
| grp_en | input | 1 | Update enable for the band named by `grp_sel` |
| mem_rd | output | 1 | Byte read strobe |
| mem_addr | output | 20 | Byte address of the read |
| mem_rdata | input | 8 | Read data, valid the cycle after `mem_rd` |
| pal_rd | output | 1 | Palette read strobe |
| pal_index | output | 8 | Palette entry requested |
| pal_red | input | 8 | Red component, valid the cycle after `pal_rd` |
| pal_green | input | 8 | Green component, valid the cycle after `pal_rd` |
| pal_blue | input | 8 | Blue component, valid the cycle after `pal_rd` |
| pix_valid | output | 1 | Pixel word offered |
| pix_ready | input | 1 | Sink accepts the pixel |
| pix_data | output | 32 | Pixel word, byte 0 in bits 7:0 |
| pix_be | output | 4 | Byte enables of `pix_data` |
| pix_sol | output | 1 | First pixel of a line |
| pix_eof | output | 1 | Last pixel of the frame |

## Verification
The bench builds the block with its default parameters: a 1024-byte pitch, a 1024-pixel maximum width and a 768-line maximum height. These are the real address layout, so a pitch or band-step error shows up directly in the upper address bits. The bench's memory content depends on those bits, so a wrong address also changes the pixel data. The defaults also bring a full 1024-pixel line, 10-line frames with a skipped middle band and a skipped final band, and random back-pressure within a short run.

// File: rtl/scan_pkg.sv
package scan_pkg;
    typedef enum logic [1:0] {
        FMT_OFF    = 2'b00,
        FMT_RAW    = 2'b01,
        FMT_BGR24  = 2'b10,
        FMT_BGRX32 = 2'b11
    } fmt_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_GROUP,
        S_FETCH,
        S_IDXCAP,
        S_LOOKUP,
        S_RGBCAP,
        S_EMIT
    } st_e;
endpackage

// File: rtl/scan_addr.sv
module scan_addr #(
    parameter int PITCH = 1024,
    parameter int MAX_W = 1024,
    parameter int MAX_H = 768,
    localparam int AW   = $clog2(PITCH * (MAX_H + 4)),
    localparam int C_W  = $clog2(MAX_W + 1),
    localparam int LN_W = $clog2(MAX_H + 4)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            step_pix,
    input  logic            step_line,
    input  logic            skip_grp,
    output logic [C_W-1:0]  col,
    output logic [LN_W-1:0] line,
    output logic [AW-1:0]   addr
);
    logic [AW-1:0] base;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            col  <= '0;
            line <= '0;
            base <= '0;
        end else if (skip_grp) begin
            col  <= '0;
            line <= line + LN_W'(4);
            base <= base + AW'(4 * PITCH);
        end else if (step_line) begin
            col  <= '0;
            line <= line + LN_W'(1);
            base <= base + AW'(PITCH);
        end else if (step_pix) begin
            col  <= col + C_W'(1);
        end
    end

    assign addr = base + AW'(col);
endmodule

// File: rtl/scan_fmt.sv
module scan_fmt
    import scan_pkg::*;
(
    input  fmt_e        fmt,
    input  logic [7:0]  idx,
    input  logic [7:0]  red,
    input  logic [7:0]  grn,
    input  logic [7:0]  blu,
    output logic [31:0] data,
    output logic [3:0]  be
);
    always_comb begin
        unique case (fmt)
            FMT_BGRX32: begin data = {8'h00, red, grn, blu}; be = 4'b1111; end
            FMT_BGR24:  begin data = {8'h00, red, grn, blu}; be = 4'b0111; end
            FMT_RAW:    begin data = {24'h0, idx};           be = 4'b0001; end
            default:    begin data = '0;                     be = 4'b0000; end
        endcase
    end
endmodule

// File: rtl/idx_scanout.sv
module idx_scanout
    import scan_pkg::*;
#(
    parameter int PITCH = 1024,
    parameter int MAX_W = 1024,
    parameter int MAX_H = 768,
    localparam int AW   = $clog2(PITCH * (MAX_H + 4)),
    localparam int C_W  = $clog2(MAX_W + 1),
    localparam int H_W  = $clog2(MAX_H + 1),
    localparam int LN_W = $clog2(MAX_H + 4),
    localparam int G_W  = $clog2((MAX_H + 3) / 4)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            frame_start,
    input  logic [1:0]      mode,
    input  logic [C_W-1:0]  act_width,
    input  logic [H_W-1:0]  act_height,
    output logic [G_W-1:0]  grp_sel,
    input  logic            grp_en,
    output logic            mem_rd,
    output logic [AW-1:0]   mem_addr,
    input  logic [7:0]      mem_rdata,
    output logic            pal_rd,
    output logic [7:0]      pal_index,
    input  logic [7:0]      pal_red,
    input  logic [7:0]      pal_green,
    input  logic [7:0]      pal_blue,
    output logic            pix_valid,
    input  logic            pix_ready,
    output logic [31:0]     pix_data,
    output logic [3:0]      pix_be,
    output logic            pix_sol,
    output logic            pix_eof
);
    st_e             st, st_n;
    fmt_e            fmt_q;
    logic [C_W-1:0]  w_q;
    logic [LN_W-1:0] h_q;
    logic [7:0]      idx_q, red_q, grn_q, blu_q;
    logic [C_W-1:0]  col;
    logic [LN_W-1:0] line;
    logic            start_ok, clear, step_pix, step_line, skip_grp;
    logic            last_col, last_line, band_tail, skip_done;
    logic [31:0]     fmt_data;
    logic [3:0]      fmt_be;

    assign start_ok  = frame_start && (mode != FMT_OFF)
                       && (act_width != '0) && (act_height != '0);
    assign last_col  = (col == w_q - C_W'(1));
    assign last_line = (line == h_q - LN_W'(1));
    assign band_tail = (line[1:0] == 2'b11);
    assign skip_done = (line + LN_W'(4) >= h_q);

    scan_addr #(.PITCH(PITCH), .MAX_W(MAX_W), .MAX_H(MAX_H)) u_addr (
        .clk(clk), .rst_n(rst_n), .clear(clear), .step_pix(step_pix),
        .step_line(step_line), .skip_grp(skip_grp),
        .col(col), .line(line), .addr(mem_addr)
    );

    scan_fmt u_fmt (
        .fmt(fmt_q), .idx(idx_q), .red(red_q), .grn(grn_q), .blu(blu_q),
        .data(fmt_data), .be(fmt_be)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_n;
    end

    // frame settings and captured pixel values
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fmt_q <= FMT_OFF;
            w_q   <= '0;
            h_q   <= '0;
            idx_q <= '0;
            red_q <= '0;
            grn_q <= '0;
            blu_q <= '0;
        end else begin
            if (st == S_IDLE && start_ok) begin
                fmt_q <= fmt_e'(mode);
                w_q   <= act_width;
                h_q   <= LN_W'(act_height);
            end
            if (st == S_IDXCAP) idx_q <= mem_rdata;
            if (st == S_RGBCAP) begin
                red_q <= pal_red;
                grn_q <= pal_green;
                blu_q <= pal_blue;
            end
        end
    end

    // next state and outputs
    always_comb begin
        st_n      = st;
        clear     = 1'b0;
        step_pix  = 1'b0;
        step_line = 1'b0;
        skip_grp  = 1'b0;
        mem_rd    = 1'b0;
        pal_rd    = 1'b0;
        pix_valid = 1'b0;
        unique case (st)
            S_IDLE: if (start_ok) begin
                clear = 1'b1;
                st_n  = S_GROUP;
            end
            S_GROUP: if (grp_en) begin
                st_n = S_FETCH;
            end else begin
                skip_grp = 1'b1;
                st_n     = skip_done ? S_IDLE : S_GROUP;
            end
            S_FETCH: begin
                mem_rd = 1'b1;
                st_n   = S_IDXCAP;
            end
            S_IDXCAP: st_n = (fmt_q == FMT_RAW) ? S_EMIT : S_LOOKUP;
            S_LOOKUP: begin
                pal_rd = 1'b1;
                st_n   = S_RGBCAP;
            end
            S_RGBCAP: st_n = S_EMIT;
            S_EMIT: begin
                pix_valid = 1'b1;
                if (pix_ready) begin
                    if (!last_col) begin
                        step_pix = 1'b1;
                        st_n     = S_FETCH;
                    end else if (last_line) begin
                        st_n = S_IDLE;
                    end else begin
                        step_line = 1'b1;
                        st_n      = band_tail ? S_GROUP : S_FETCH;
                    end
                end
            end
            default: st_n = S_IDLE;
        endcase
    end

    assign grp_sel   = G_W'(line >> 2);
    assign pal_index = idx_q;
    assign pix_data  = fmt_data;
    assign pix_be    = fmt_be;
    assign pix_sol   = pix_valid && (col == '0);
    assign pix_eof   = pix_valid && last_col && last_line;

    // R10: a stalled pixel holds all of its fields
    a_r10_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid && !pix_ready |=> pix_valid && $stable(pix_data)
            && $stable(pix_be) && $stable(pix_sol) && $stable(pix_eof));

    // R3: reads are never back to back
    a_r3_single_read: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd);

    // R3: reads stay inside the active width of the line
    a_r3_in_width: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> (mem_addr % AW'(PITCH)) < AW'(w_q));

    // R6: raw frames never touch the palette
    a_r6_raw_no_pal: assert property (@(posedge clk) disable iff (!rst_n)
        fmt_q == FMT_RAW |-> !pal_rd);

    // R4: padded pixels enable all four bytes
    a_r4_full_be: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid && fmt_q == FMT_BGRX32 |-> pix_be == 4'b1111);

    // R7: an off-mode start request triggers no read
    a_r7_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        st == S_IDLE && mode == FMT_OFF |=> !mem_rd);
endmodule

// File: tb/sim_idx_scanout.sv
module sim_idx_scanout;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_start = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic [10:0] act_width = 11'd0;
    logic [9:0]  act_height = 10'd0;
    logic [7:0]  grp_sel;
    logic        grp_en;
    logic        mem_rd;
    logic [19:0] mem_addr;
    logic [7:0]  mem_rdata = 8'h0;
    logic        pal_rd;
    logic [7:0]  pal_index;
    logic [7:0]  pal_red = 8'h0, pal_green = 8'h0, pal_blue = 8'h0;
    logic        pix_valid;
    logic        pix_ready = 1'b1;
    logic [31:0] pix_data;
    logic [3:0]  pix_be;
    logic        pix_sol, pix_eof;

    logic [255:0] grp_mask = '1;
    bit           bp_on = 1'b0;
    int           errors = 0, checks = 0;

    logic [31:0] cap_d [0:2047];
    logic [3:0]  cap_b [0:2047];
    logic        cap_s [0:2047];
    logic        cap_e [0:2047];
    int          cap_n = 0;
    logic [19:0] maddr [0:2047];
    int          mn = 0, pal_cnt = 0, eof_cnt = 0;

    logic [31:0] ex_d [0:2047];
    logic [3:0]  ex_b [0:2047];
    logic        ex_s [0:2047];
    logic        ex_e [0:2047];
    int          ex_n = 0;

    always #2 clk = ~clk;

    idx_scanout u0 (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .mode(mode),
        .act_width(act_width), .act_height(act_height), .grp_sel(grp_sel),
        .grp_en(grp_en), .mem_rd(mem_rd), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .pal_rd(pal_rd), .pal_index(pal_index),
        .pal_red(pal_red), .pal_green(pal_green), .pal_blue(pal_blue),
        .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_data(pix_data),
        .pix_be(pix_be), .pix_sol(pix_sol), .pix_eof(pix_eof)
    );

    function automatic logic [7:0] vbyte(input logic [19:0] a);
        return a[7:0] ^ {a[9:8], a[15:10]} ^ {a[19:16], 4'h9};
    endfunction

    assign grp_en = grp_mask[grp_sel];

    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= vbyte(mem_addr);
        if (pal_rd) begin
            pal_red   <= pal_index ^ 8'hA5;
            pal_green <= pal_index + 8'd17;
            pal_blue  <= ~pal_index;
        end
    end

    always @(negedge clk) begin
        if (pix_valid && pix_ready && cap_n < 2048) begin
            cap_d[cap_n] = pix_data;
            cap_b[cap_n] = pix_be;
            cap_s[cap_n] = pix_sol;
            cap_e[cap_n] = pix_eof;
            if (pix_eof) eof_cnt++;
            cap_n++;
        end
        if (mem_rd && mn < 2048) begin
            maddr[mn] = mem_addr;
            mn++;
        end
        if (pal_rd) pal_cnt++;
    end

    initial begin
        logic [15:0] lf;
        lf = 16'hACE1;
        forever begin
            @(posedge clk);
            #1;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            pix_ready = bp_on ? lf[0] : 1'b1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic clear_log();
        cap_n = 0; mn = 0; pal_cnt = 0; eof_cnt = 0; ex_n = 0;
    endtask

    task automatic build_exp(input logic [1:0] md, input int w, input int h);
        for (int y = 0; y < h; y++) begin
            if (grp_mask[y / 4]) begin
                for (int x = 0; x < w; x++) begin
                    logic [7:0] ix;
                    ix = vbyte(20'(y * 1024 + x));
                    if (md == 2'b01) begin
                        ex_d[ex_n] = {24'h0, ix};
                        ex_b[ex_n] = 4'b0001;
                    end else begin
                        ex_d[ex_n] = {8'h00, ix ^ 8'hA5, ix + 8'd17, ~ix};
                        ex_b[ex_n] = (md == 2'b11) ? 4'b1111 : 4'b0111;
                    end
                    ex_s[ex_n] = (x == 0);
                    ex_e[ex_n] = (x == w - 1) && (y == h - 1);
                    ex_n++;
                end
            end
        end
    endtask

    task automatic start(input logic [1:0] md, input int w, input int h);
        @(posedge clk); #1;
        mode = md; act_width = 11'(w); act_height = 10'(h); frame_start = 1'b1;
        @(posedge clk); #1;
        frame_start = 1'b0;
    endtask

    task automatic finish_wait();
        int t;
        t = 0;
        while (cap_n < ex_n && t < 40000) begin
            @(posedge clk);
            t++;
        end
        repeat (40) @(posedge clk);
    endtask

    task automatic compare(input string req);
        chk(cap_n == ex_n, req, "pixel count", 32'(cap_n), 32'(ex_n));
        for (int i = 0; i < ex_n && i < cap_n; i++) begin
            chk(cap_d[i] == ex_d[i], req, $sformatf("data[%0d]", i), cap_d[i], ex_d[i]);
            chk(cap_b[i] == ex_b[i], req, $sformatf("be[%0d]", i), 32'(cap_b[i]), 32'(ex_b[i]));
            chk(cap_s[i] == ex_s[i], "R9", $sformatf("sol[%0d]", i), 32'(cap_s[i]), 32'(ex_s[i]));
            chk(cap_e[i] == ex_e[i], "R9", $sformatf("eof[%0d]", i), 32'(cap_e[i]), 32'(ex_e[i]));
        end
    endtask

    task automatic t_reset();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!pix_valid && !mem_rd && !pal_rd, "R1", "idle after reset",
            {29'h0, pix_valid, mem_rd, pal_rd}, 32'h0);
    endtask

    task automatic t_pad32();
        clear_log(); grp_mask = '1;
        build_exp(2'b11, 3, 2);
        start(2'b11, 3, 2);
        finish_wait();
        compare("R4");
        chk(mn == 6 && maddr[3] == 20'd1024, "R3", "second line address",
            32'(maddr[3]), 32'd1024);
    endtask

    task automatic t_pack24();
        clear_log(); grp_mask = '1;
        build_exp(2'b10, 5, 3);
        start(2'b10, 5, 3);
        finish_wait();
        compare("R5");
    endtask

    task automatic t_raw();
        clear_log(); grp_mask = '1;
        build_exp(2'b01, 4, 5);
        start(2'b01, 4, 5);
        finish_wait();
        compare("R6");
        chk(pal_cnt == 0, "R6", "palette reads in raw mode", 32'(pal_cnt), 32'd0);
    endtask

    task automatic t_off();
        clear_log();
        start(2'b00, 4, 4);
        repeat (60) @(posedge clk);
        chk(cap_n == 0 && mn == 0, "R7", "activity in off mode",
            32'(cap_n + mn), 32'd0);
    endtask

    task automatic t_skip_mid();
        clear_log(); grp_mask = '0; grp_mask[0] = 1'b1; grp_mask[2] = 1'b1;
        build_exp(2'b10, 2, 10);
        start(2'b10, 2, 10);
        finish_wait();
        compare("R8");
        chk(maddr[8] == 20'd8192, "R8", "band after skip address",
            32'(maddr[8]), 32'd8192);
    endtask

    task automatic t_skip_last();
        clear_log(); grp_mask = '0; grp_mask[0] = 1'b1;
        build_exp(2'b11, 2, 6);
        start(2'b11, 2, 6);
        finish_wait();
        compare("R8");
        chk(eof_cnt == 0, "R9", "eof with final band skipped", 32'(eof_cnt), 32'd0);
    endtask

    task automatic t_midframe();
        clear_log(); grp_mask = '1;
        build_exp(2'b11, 4, 2);
        start(2'b11, 4, 2);
        repeat (5) @(posedge clk);
        #1 act_width = 11'd1; act_height = 10'd1; mode = 2'b01; frame_start = 1'b1;
        @(posedge clk); #1 frame_start = 1'b0;
        finish_wait();
        compare("R2");
    endtask

    task automatic t_backpressure();
        clear_log(); grp_mask = '1; bp_on = 1'b1;
        build_exp(2'b11, 7, 5);
        start(2'b11, 7, 5);
        finish_wait();
        bp_on = 1'b0;
        compare("R10");
    endtask

    task automatic t_full_width();
        clear_log(); grp_mask = '1;
        build_exp(2'b01, 1024, 1);
        start(2'b01, 1024, 1);
        finish_wait();
        compare("R11");
        chk(mn == 1024 && maddr[1023] == 20'd1023, "R11", "last column address",
            32'(maddr[1023]), 32'd1023);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
    end

    initial begin
        t_reset();
        t_pad32();
        t_pack24();
        t_raw();
        t_off();
        t_skip_mid();
        t_skip_last();
        t_midframe();
        t_backpressure();
        t_full_width();
        summary();
    end
endmodule